// File: doc/BRIEF.md
# Transmit Sample Clock and Minimum-Width Pulse Conditioner

This block sits at the front of a low-power serial transmitter. It divides the system clock by a factor chosen with a 3-bit rate code and produces a single-cycle sample strobe. On each strobe it samples the asynchronous transmit data line, after a two-flop synchroniser, and produces a conditioned data bit for the downstream compressor. The compressor needs every level on that bit to last at least ten sample periods.

A level that changes back sooner than that is held, or stretched, until it has lasted exactly ten samples. The output then takes whatever level the input has at that moment, and the next pulse is timed from that point. At most three stretched pulses may follow one another. After the third, short pulses pass through unchanged until a pulse of ten or more samples restores stretching. A flag shows when the output is being held against a differing input. The maximum usable data rate is one tenth of the sample rate, with a 10% margin for jitter.

Top module: `txd_pulse_shaper`

## Requirements
- R1: The rate code picks the sample divisor: 3'b011 gives 160, 3'b100 gives 80, 3'b101 gives 40, 3'b110 gives 20, 3'b111 gives 15 clock cycles between successive strobes.
- R2: The codes 3'b000, 3'b001 and 3'b010 select a divisor of 160.
- R3: The rate code is captured only while rstN is low; changing it after reset leaves the strobe period unchanged.
- R4: sampleStb is high for exactly one clock cycle per sample period.
- R5: While rstN is low, shapedBit is 1, stretchFlag is 0 and sampleStb is 0.
- R6: An input level lasting ten or more samples appears on shapedBit with its length in samples preserved.
- R7: An output level whose input lasted fewer than ten samples is held for exactly ten samples, provided fewer than three stretches precede it consecutively.
- R8: stretchFlag is 1 for each sample period in which shapedBit is held against a differing input; a pulse of n < 10 samples keeps it high for 10 − n sample periods, and it is 0 on any period that starts with a change of shapedBit.
- R9: After three consecutive stretched pulses, further short pulses pass through with their own length.
- R10: An output level lasting ten or more samples without being held clears the consecutive-stretch count, so the next short pulse is stretched again.
- R11: Input changes during a stretch are tracked: when the stretch ends, shapedBit takes the current input level, and the pulse that follows is timed from the end of the stretch.
- R12: shapedBit changes only in the clock cycle right after a sampleStb cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset; also loads the rate code |
| rateCode | input | 3 | Sample divisor selection (see R1, R2) |
| txdRaw | input | 1 | Asynchronous transmit data line |
| sampleStb | output | 1 | One-cycle strobe per sample period |
| shapedBit | output | 1 | Conditioned data bit, minimum ten samples per level |
| stretchFlag | output | 1 | High while a short pulse is being stretched |

## Verification
A wrong divisor or a damaged divider counter shows as a wrong strobe spacing within the first two strobes after reset. A run counter or consecutive-stretch counter in the wrong state shows as an output pulse of the wrong length. This appears one pulse after the fault, at most ten samples later, or as a fourth pulse that is stretched when it should pass unchanged. A fault in the hold state shows on stretchFlag in the same sample period as the stretch it belongs to.

// File: rtl/shaper_pkg.sv
package shaper_pkg;

  localparam int DIV_MAX = 160;
  localparam int DIV_W   = $clog2(DIV_MAX + 1);

  // strobes from control to datapath, valid for one clock
  typedef struct packed {
    logic sample;   // sample period boundary
    logic toggle;   // invert the conditioned output
    logic hold;     // output held against a differing input
  } shapeCtl_t;

  function automatic logic [DIV_W-1:0] divisorFor(input logic [2:0] code);
    case (code)
      3'b100:  return DIV_W'(80);
      3'b101:  return DIV_W'(40);
      3'b110:  return DIV_W'(20);
      3'b111:  return DIV_W'(15);
      default: return DIV_W'(DIV_MAX);
    endcase
  endfunction

endpackage

// File: rtl/shaper_ctrl.sv
module shaper_ctrl
  import shaper_pkg::*;
#(
  parameter int MinRun     = 10,
  parameter int MaxStretch = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] rateCode,
  input  logic       syncBit,
  input  logic       curBit,
  input  logic       heldNow,
  output shapeCtl_t  ctl
);

  localparam int RunW = $clog2(MinRun + 1);
  localparam int ShW  = $clog2(MaxStretch + 1);
  localparam logic [RunW-1:0] MinRunV     = RunW'(MinRun);
  localparam logic [ShW-1:0]  MaxStretchV = ShW'(MaxStretch);

  logic [DIV_W-1:0] divQ;
  logic [DIV_W-1:0] divCnt;
  logic             stbQ;
  logic [RunW-1:0]  runCnt;
  logic [ShW-1:0]   shortCnt;

  // rate is captured only while reset is held
  always_ff @(posedge clk) begin
    if (!rstN) divQ <= divisorFor(rateCode);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
      stbQ   <= 1'b0;
    end else if (divCnt == divQ - 1'b1) begin
      divCnt <= '0;
      stbQ   <= 1'b1;
    end else begin
      divCnt <= divCnt + 1'b1;
      stbQ   <= 1'b0;
    end
  end

  logic differ, longEnough, passThru, toggleNow, holdNow;

  always_comb begin
    differ     = syncBit != curBit;
    longEnough = runCnt >= MinRunV;
    passThru   = shortCnt == MaxStretchV;
    toggleNow  = stbQ && differ && (longEnough || passThru);
    holdNow    = stbQ && differ && !toggleNow;
    ctl.sample = stbQ;
    ctl.toggle = toggleNow;
    ctl.hold   = holdNow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt   <= MinRunV;
      shortCnt <= '0;
    end else if (stbQ) begin
      if (toggleNow) begin
        runCnt <= RunW'(1);
        if (heldNow)         shortCnt <= shortCnt + 1'b1;
        else if (longEnough) shortCnt <= '0;
      end else if (!longEnough) begin
        runCnt <= runCnt + 1'b1;
      end
    end
  end

  // independent spacing monitor for the strobe
  logic [DIV_W:0] gapCnt;
  logic           seenStb;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gapCnt  <= '0;
      seenStb <= 1'b0;
    end else if (stbQ) begin
      gapCnt  <= (DIV_W+1)'(1);
      seenStb <= 1'b1;
    end else if (gapCnt != '1) begin
      gapCnt <= gapCnt + 1'b1;
    end
  end

  AST_STROBE_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    (stbQ && seenStb) |-> (gapCnt == {1'b0, divQ})); // R1
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    stbQ |=> !stbQ); // R4
  AST_STRETCH_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(heldNow) |-> (shortCnt < MaxStretchV)); // R9

endmodule

// File: rtl/shaper_dp.sv
module shaper_dp
  import shaper_pkg::*;
#(
  parameter int SyncStages = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      txdRaw,
  input  shapeCtl_t ctl,
  output logic      syncBit,
  output logic      shapedBit,
  output logic      stretchFlag
);

  logic [SyncStages-1:0] syncQ;

  for (genvar g = 0; g < SyncStages; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[0] <= 1'b1;
        else       syncQ[0] <= txdRaw;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[g] <= 1'b1;
        else       syncQ[g] <= syncQ[g-1];
      end
    end
  end

  assign syncBit = syncQ[SyncStages-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shapedBit   <= 1'b1;
      stretchFlag <= 1'b0;
    end else if (ctl.sample) begin
      if (ctl.toggle) shapedBit <= ~shapedBit;
      stretchFlag <= ctl.hold;
    end
  end

  AST_OUT_ON_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !$past(ctl.sample) |-> (shapedBit == $past(shapedBit))); // R12
  AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (shapedBit != $past(shapedBit)) |-> !stretchFlag); // R8

endmodule

// File: rtl/txd_pulse_shaper.sv
module txd_pulse_shaper
  import shaper_pkg::*;
#(
  parameter int MinRun     = 10,
  parameter int MaxStretch = 3,
  parameter int SyncStages = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] rateCode,
  input  logic       txdRaw,
  output logic       sampleStb,
  output logic       shapedBit,
  output logic       stretchFlag
);

  shapeCtl_t ctl;
  logic      syncBit;

  shaper_ctrl #(.MinRun(MinRun), .MaxStretch(MaxStretch)) ctrl_i (
    .clk(clk), .rstN(rstN), .rateCode(rateCode), .syncBit(syncBit),
    .curBit(shapedBit), .heldNow(stretchFlag), .ctl(ctl)
  );

  shaper_dp #(.SyncStages(SyncStages)) dp_i (
    .clk(clk), .rstN(rstN), .txdRaw(txdRaw), .ctl(ctl),
    .syncBit(syncBit), .shapedBit(shapedBit), .stretchFlag(stretchFlag)
  );

  assign sampleStb = ctl.sample;

endmodule

// File: tb/txd_pulse_shaper_tb_top.sv
module txd_pulse_shaper_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] rateCode = 3'b111;
  logic       txdRaw = 1'b1;
  logic       sampleStb, shapedBit, stretchFlag;

  int checks = 0;
  int failures = 0;

  txd_pulse_shaper dut_i (
    .clk(clk), .rstN(rstN), .rateCode(rateCode), .txdRaw(txdRaw),
    .sampleStb(sampleStb), .shapedBit(shapedBit), .stretchFlag(stretchFlag)
  );

  always #4 clk = ~clk;

  bit patBits [0:255];
  bit recOut  [0:255];
  bit recFlg  [0:255];
  int patLen;
  int runs [0:15];
  int nRuns, flagRises, flagHigh, midChanges;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic doReset(input logic [2:0] code);
    rstN = 1'b0;
    rateCode = code;
    txdRaw = 1'b1;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic waitStb();
    do @(negedge clk); while (!sampleStb);
  endtask

  task automatic measure(output int period, output int highLen);
    waitStb();
    highLen = 0;
    while (sampleStb) begin highLen++; @(negedge clk); end
    period = highLen;
    while (!sampleStb) begin period++; @(negedge clk); end
  endtask

  task automatic testReset();
    rstN = 1'b0;
    rateCode = 3'b111;
    txdRaw = 1'b0;
    repeat (6) @(negedge clk);
    chk("R5", "shapedBit in reset", shapedBit, 1);
    chk("R5", "stretchFlag in reset", stretchFlag, 0);
    chk("R5", "sampleStb in reset", sampleStb, 0);
  endtask

  task automatic testRates();
    logic [2:0] codes [0:7];
    int         exps  [0:7];
    int per, hi;
    codes = '{3'b011, 3'b100, 3'b101, 3'b110, 3'b111, 3'b000, 3'b001, 3'b010};
    exps  = '{160, 80, 40, 20, 15, 160, 160, 160};
    for (int k = 0; k < 8; k++) begin
      doReset(codes[k]);
      measure(per, hi);
      chk(k < 5 ? "R1" : "R2", $sformatf("period code=%b", codes[k]), per, exps[k]);
      if (k == 4) chk("R4", "strobe width", hi, 1);
    end
    doReset(3'b101);
    rateCode = 3'b111;
    measure(per, hi);
    measure(per, hi);
    chk("R3", "period after late code change", per, 40);
    chk("R4", "strobe width at divisor 40", hi, 1);
  endtask

  task automatic clearPat();
    patLen = 0;
  endtask

  task automatic addRun(input bit v, input int n);
    for (int k = 0; k < n; k++) begin
      patBits[patLen] = v;
      patLen++;
    end
  endtask

  // one input level per sample period; output recorded once per period
  task automatic play();
    midChanges = 0;
    for (int i = 0; i < patLen; i++) begin
      waitStb();
      if (i > 0 && shapedBit != recOut[i-1]) midChanges++;
      txdRaw = patBits[i];
      @(negedge clk);
      recOut[i] = shapedBit;
      recFlg[i] = stretchFlag;
    end
    nRuns = 0; flagRises = 0; flagHigh = 0;
    for (int i = 0; i < patLen; i++) begin
      if (recFlg[i]) flagHigh++;
      if (recFlg[i] && (i == 0 || !recFlg[i-1])) flagRises++;
    end
    begin
      int i = 0;
      int len = 0;
      bit cur;
      while (i < patLen && recOut[i]) i++;
      cur = recOut[i];
      for (; i < patLen; i++) begin
        if (recOut[i] == cur) len++;
        else begin
          if (nRuns < 16) runs[nRuns] = len;
          nRuns++;
          cur = recOut[i];
          len = 1;
        end
      end
    end
    chk("R12", "output changes away from strobe", midChanges, 0);
  endtask

  task automatic testLongPulses();
    doReset(3'b111);
    clearPat();
    addRun(1, 3); addRun(0, 12); addRun(1, 15); addRun(0, 11); addRun(1, 14);
    play();
    chk("R6", "run count", nRuns, 3);
    chk("R6", "low run 12", runs[0], 12);
    chk("R6", "high run 15", runs[1], 15);
    chk("R6", "low run 11", runs[2], 11);
    chk("R8", "no stretch on long pulses", flagRises, 0);
  endtask

  task automatic testSingleStretch();
    doReset(3'b111);
    clearPat();
    addRun(1, 3); addRun(0, 3); addRun(1, 20); addRun(0, 9); addRun(1, 14);
    play();
    chk("R7", "3-sample pulse stretched", runs[0], 10);
    chk("R6", "following long high", runs[1], 13);
    chk("R7", "9-sample pulse stretched", runs[2], 10);
    chk("R8", "flag high periods (7+1)", flagHigh, 8);
    chk("R8", "flag episodes", flagRises, 2);
  endtask

  task automatic testStretchLimit();
    doReset(3'b111);
    clearPat();
    addRun(1, 3); addRun(0, 4); addRun(1, 10); addRun(0, 10); addRun(1, 10);
    addRun(0, 10); addRun(1, 14); addRun(0, 2); addRun(1, 14);
    play();
    chk("R7", "first stretched", runs[0], 10);
    chk("R7", "second stretched", runs[1], 10);
    chk("R7", "third stretched", runs[2], 10);
    chk("R9", "fourth short passes unstretched", runs[3], 4);
    chk("R9", "next low not held", runs[4], 10);
    chk("R6", "long high after passthrough", runs[5], 14);
    chk("R10", "stretch restored after long pulse", runs[6], 10);
    chk("R10", "stretch episodes", flagRises, 4);
  endtask

  task automatic testTracking();
    doReset(3'b111);
    clearPat();
    addRun(1, 3); addRun(0, 12); addRun(1, 2); addRun(0, 12); addRun(1, 14);
    play();
    chk("R6", "leading long low", runs[0], 12);
    chk("R11", "2-sample high stretched", runs[1], 10);
    chk("R11", "low timed from stretch end", runs[2], 10);
    chk("R11", "stretch episodes", flagRises, 2);
  endtask

  initial begin
    testReset();
    testRates();
    testLongPulses();
    testSingleStretch();
    testStretchLimit();
    testTracking();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog all-requirements actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule